// File: doc/BRIEF.md
# Command-Word Register Bridge

This block takes a stream of bytes from a host-side FIFO and turns every four of them into one 32-bit command word. Bytes arrive most-significant first. The top bit of the word selects the operation: a set bit asks for a read and a clear bit asks for a write. A 12-bit register address follows. The low sixteen bits are the payload of a write. Bits 30 to 28 carry no meaning and the bridge never looks at them.

Each address falls into one register class. Configuration registers can be written and read back. Status registers show values that the surrounding logic drives, and they can only be read. Action registers can only be written, and each write produces a single-cycle start pulse. A set of three indirect registers gives access to a small internal memory: a transfer count, a memory pointer and a data port.

Every read command places a 16-bit answer in a one-entry return slot, which the host drains through a valid/ready port. When that slot is still occupied, a read command waits, and the byte input is closed until the command can finish.

Top module: `cmd_reg_bridge`

## Requirements
- R1: Four accepted bytes (`in_valid` and `in_ready` both high at a clock edge) form one command, first byte in bits 31..24 and last byte in bits 7..0. After the fourth byte `in_ready` is low until that command has executed. A command executes no earlier than the clock edge after its fourth byte.
- R2: Bit 31 set means read and bit 31 clear means write. Bits 27..16 hold the address and bits 15..0 hold the write data. The values of bits 30..28 change nothing.
- R3: Configuration register i sits at address 0x010+i. A write stores the 16 data bits, which appear on `cfg_out[16*i+15:16*i]` from the edge on which the command executes. A read returns the stored value.
- R4: Status register i sits at address 0x020+i. A read returns `status_in[16*i+15:16*i]` as sampled on the executing edge. A write changes nothing.
- R5: Action register i sits at address 0x030+i. A write drives `act_pulse[i]` high for exactly one cycle, with `act_arg` set to the data bits. At most one pulse bit is high at a time. A read returns 0.
- R6: The count register (0x040) and the pointer register (0x041) can be written and read. The pointer keeps only log2(MEM_DEPTH) bits and wraps from the last memory word to word 0.
- R7: A write to the data port (0x042) while the count is nonzero stores the data at the pointer, advances the pointer by one and lowers the count by one. While the count is zero, such a write is ignored.
- R8: A read of the data port while the count is nonzero returns the memory word at the pointer, then advances the pointer and lowers the count. While the count is zero, it returns 0 and moves nothing.
- R9: A read answer stays on `out_data`, with `out_valid` high and the value unchanged, until the host accepts it. A read command that arrives while the slot is full waits with `in_ready` low. Answers leave in command order and none is lost.
- R10: A read of any address outside the maps above returns 0. A write to such an address changes nothing.
- R11: After reset, all configuration registers, the count, the pointer and the memory are zero, `out_valid` is low, `in_ready` is high and no pulse is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Host byte available |
| in_data | input | 8 | Host byte |
| in_ready | output | 1 | Bridge accepts a byte this cycle |
| out_valid | output | 1 | Read answer waiting |
| out_ready | input | 1 | Host takes the read answer |
| out_data | output | 16 | Read answer |
| status_in | input | 16*NSTAT | Values shown by the status registers |
| cfg_out | output | 16*NCFG | Contents of the configuration registers |
| act_pulse | output | NACT | One-cycle start pulse for each action register |
| act_arg | output | 16 | Data of the most recent action write |

## Verification
Some properties are checked on every cycle. A waiting answer must hold steady until the host accepts it. A read must stall while the slot is full. The byte input must close after a fourth byte. At most one start pulse may be high, and only after a command has executed. The configuration outputs may change only on an executing command. Each data-port store must lower the count by exactly one. Other behaviour can only be shown by the bench's scenarios. These include the actual values returned per register class, the fact that the undefined bits have no effect, pointer wraparound, writes that are ignored once the count reaches zero, unmapped addresses, and the order of answers once a stall has ended. For these, the scenarios use a per-cycle behavioural model together with fixed expected values.

// File: rtl/bridge_pkg.sv
package bridge_pkg;
  localparam int CMD_W   = 32;
  localparam int WORD_W  = 16;
  localparam int RADDR_W = 12;
  localparam int IDX_W   = 8;

  localparam logic [RADDR_W-1:0] CFG_BASE  = 12'h010;
  localparam logic [RADDR_W-1:0] STAT_BASE = 12'h020;
  localparam logic [RADDR_W-1:0] ACT_BASE  = 12'h030;
  localparam logic [RADDR_W-1:0] IND_BASE  = 12'h040;

  typedef enum logic [2:0] {
    CL_NONE, CL_CFG, CL_STAT, CL_ACT, CL_ICNT, CL_IPTR, CL_IDAT
  } reg_class_e;

  function automatic logic cmd_is_read(input logic [CMD_W-1:0] w);
    return w[31];
  endfunction

  function automatic logic [RADDR_W-1:0] cmd_addr(input logic [CMD_W-1:0] w);
    return w[27:16];
  endfunction

  function automatic logic [WORD_W-1:0] cmd_data(input logic [CMD_W-1:0] w);
    return w[15:0];
  endfunction

  function automatic logic in_window(input logic [RADDR_W-1:0] a,
                                     input logic [RADDR_W-1:0] base,
                                     input int n);
    return (int'(a) >= int'(base)) && (int'(a) < int'(base) + n);
  endfunction

  function automatic logic [WORD_W-1:0] count_down(input logic [WORD_W-1:0] c);
    return c - 16'd1;
  endfunction
endpackage

// File: rtl/cmd_assembler.sv
module cmd_assembler
  import bridge_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  output logic             in_ready,
  input  logic             take,
  output logic [CMD_W-1:0] cmd_word,
  output logic             cmd_pend,
  output logic [1:0]       byte_idx
);
  logic accept;

  assign in_ready = !cmd_pend;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_word <= '0;
      cmd_pend <= 1'b0;
      byte_idx <= 2'd0;
    end else begin
      if (take) cmd_pend <= 1'b0;
      if (accept) begin
        cmd_word <= {cmd_word[CMD_W-9:0], in_data};
        if (byte_idx == 2'd3) begin
          byte_idx <= 2'd0;
          cmd_pend <= 1'b1;
        end else begin
          byte_idx <= byte_idx + 2'd1;
        end
      end
    end
  end
endmodule

// File: rtl/reg_addr_decode.sv
module reg_addr_decode
  import bridge_pkg::*;
#(
  parameter int NCFG  = 4,
  parameter int NSTAT = 2,
  parameter int NACT  = 4
) (
  input  logic [RADDR_W-1:0] addr,
  output reg_class_e         cls,
  output logic [IDX_W-1:0]   idx
);
  logic [RADDR_W-1:0] off;

  always_comb begin
    cls = CL_NONE;
    off = '0;
    if (in_window(addr, CFG_BASE, NCFG)) begin
      cls = CL_CFG;
      off = addr - CFG_BASE;
    end else if (in_window(addr, STAT_BASE, NSTAT)) begin
      cls = CL_STAT;
      off = addr - STAT_BASE;
    end else if (in_window(addr, ACT_BASE, NACT)) begin
      cls = CL_ACT;
      off = addr - ACT_BASE;
    end else if (addr == IND_BASE) begin
      cls = CL_ICNT;
    end else if (addr == IND_BASE + 12'd1) begin
      cls = CL_IPTR;
    end else if (addr == IND_BASE + 12'd2) begin
      cls = CL_IDAT;
    end
  end

  assign idx = off[IDX_W-1:0];
endmodule

// File: rtl/ind_mem_port.sv
module ind_mem_port
  import bridge_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_cnt,
  input  logic              wr_ptr,
  input  logic              wr_dat,
  input  logic              rd_dat,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] count,
  output logic [PW-1:0]     ptr,
  output logic [WORD_W-1:0] rdata,
  output logic              dat_wr_go,
  output logic              dat_rd_go
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic              live;

  assign live      = (count != '0);
  assign dat_wr_go = wr_dat && live;
  assign dat_rd_go = rd_dat && live;
  assign rdata     = live ? mem[ptr] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      ptr   <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (wr_cnt) count <= wdata;
      if (wr_ptr) ptr <= wdata[PW-1:0];
      if (dat_wr_go || dat_rd_go) begin
        ptr   <= ptr + 1'b1;
        count <= count_down(count);
      end
      if (dat_wr_go) mem[ptr] <= wdata;
    end
  end
endmodule

// File: rtl/cmd_reg_bridge.sv
module cmd_reg_bridge
  import bridge_pkg::*;
#(
  parameter int NCFG      = 4,
  parameter int NSTAT     = 2,
  parameter int NACT      = 4,
  parameter int MEM_DEPTH = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [7:0]            in_data,
  output logic                  in_ready,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [WORD_W-1:0]     out_data,
  input  logic [NSTAT*16-1:0]   status_in,
  output logic [NCFG*16-1:0]    cfg_out,
  output logic [NACT-1:0]       act_pulse,
  output logic [WORD_W-1:0]     act_arg
);
  localparam int PW = $clog2(MEM_DEPTH);

  logic [CMD_W-1:0]   cmd_word;
  logic               cmd_pend;
  logic [1:0]         byte_idx;
  logic               cmd_rd;
  logic [RADDR_W-1:0] cmd_a;
  logic [WORD_W-1:0]  cmd_wdata;
  reg_class_e         cls;
  logic [IDX_W-1:0]   idx;
  logic               slot_free;
  logic               exec_fire;
  logic               wr_fire;
  logic               rd_fire;
  logic [WORD_W-1:0]  ind_count;
  logic [PW-1:0]      ind_ptr;
  logic [WORD_W-1:0]  ind_rdata;
  logic               dat_wr_go;
  logic               dat_rd_go;
  logic [WORD_W-1:0]  rd_value;
  logic [WORD_W-1:0]  cfg_q [NCFG];

  cmd_assembler u_asm (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .take(exec_fire), .cmd_word(cmd_word),
    .cmd_pend(cmd_pend), .byte_idx(byte_idx)
  );

  assign cmd_rd    = cmd_is_read(cmd_word);
  assign cmd_a     = cmd_addr(cmd_word);
  assign cmd_wdata = cmd_data(cmd_word);

  reg_addr_decode #(.NCFG(NCFG), .NSTAT(NSTAT), .NACT(NACT)) u_dec (
    .addr(cmd_a), .cls(cls), .idx(idx)
  );

  assign slot_free = !out_valid || out_ready;
  assign exec_fire = cmd_pend && (!cmd_rd || slot_free);
  assign wr_fire   = exec_fire && !cmd_rd;
  assign rd_fire   = exec_fire && cmd_rd;

  ind_mem_port #(.DEPTH(MEM_DEPTH)) u_ind (
    .clk(clk), .rst_n(rst_n),
    .wr_cnt(wr_fire && cls == CL_ICNT),
    .wr_ptr(wr_fire && cls == CL_IPTR),
    .wr_dat(wr_fire && cls == CL_IDAT),
    .rd_dat(rd_fire && cls == CL_IDAT),
    .wdata(cmd_wdata), .count(ind_count), .ptr(ind_ptr),
    .rdata(ind_rdata), .dat_wr_go(dat_wr_go), .dat_rd_go(dat_rd_go)
  );

  for (genvar g = 0; g < NCFG; g++) begin : g_cfg
    always_ff @(posedge clk) begin
      if (!rst_n) cfg_q[g] <= '0;
      else if (wr_fire && cls == CL_CFG && idx == IDX_W'(g)) cfg_q[g] <= cmd_wdata;
    end
    assign cfg_out[g*16 +: 16] = cfg_q[g];
  end

  for (genvar g = 0; g < NACT; g++) begin : g_act
    always_ff @(posedge clk) begin
      if (!rst_n) act_pulse[g] <= 1'b0;
      else        act_pulse[g] <= wr_fire && cls == CL_ACT && idx == IDX_W'(g);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) act_arg <= '0;
    else if (wr_fire && cls == CL_ACT) act_arg <= cmd_wdata;
  end

  always_comb begin
    rd_value = '0;
    case (cls)
      CL_CFG:  for (int i = 0; i < NCFG; i++)  if (idx == IDX_W'(i)) rd_value = cfg_q[i];
      CL_STAT: for (int i = 0; i < NSTAT; i++) if (idx == IDX_W'(i)) rd_value = status_in[i*16 +: 16];
      CL_ICNT: rd_value = ind_count;
      CL_IPTR: rd_value = WORD_W'(ind_ptr);
      CL_IDAT: rd_value = ind_rdata;
      default: rd_value = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (rd_fire) begin
      out_valid <= 1'b1;
      out_data  <= rd_value;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/bridge_checks.sv
module bridge_checks #(
  parameter int NCFG = 4,
  parameter int NACT = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [15:0]      out_data,
  input logic [NACT-1:0]  act_pulse,
  input logic [NCFG*16-1:0] cfg_out,
  input logic [1:0]       byte_idx,
  input logic             cmd_pend,
  input logic             cmd_rd,
  input logic             exec_fire,
  input logic             dat_wr_go,
  input logic [15:0]      ind_count
);
  a_r9_answer_held: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  a_r9_read_waits: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_pend && cmd_rd && out_valid && !out_ready |=> cmd_pend);

  a_r1_closed_after_fourth: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && byte_idx == 2'd3 |=> !in_ready);

  a_r5_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(act_pulse));

  a_r5_pulse_from_command: assert property (@(posedge clk) disable iff (!rst_n)
    act_pulse != '0 |-> $past(exec_fire));

  a_r3_cfg_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_fire |=> $stable(cfg_out));

  a_r7_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
    dat_wr_go |=> ind_count == $past(ind_count) - 16'd1);
endmodule

bind cmd_reg_bridge bridge_checks #(.NCFG(NCFG), .NACT(NACT)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .act_pulse(act_pulse), .cfg_out(cfg_out), .byte_idx(byte_idx),
  .cmd_pend(cmd_pend), .cmd_rd(cmd_rd), .exec_fire(exec_fire),
  .dat_wr_go(dat_wr_go), .ind_count(ind_count)
);

// File: tb/sim_cmd_reg_bridge.sv
module sim_cmd_reg_bridge;
  localparam int NCFG = 4, NSTAT = 2, NACT = 4, DEPTH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [15:0] out_data;
  logic [NSTAT*16-1:0] status_in = {16'hA5A5, 16'h1357};
  logic [NCFG*16-1:0] cfg_out;
  logic [NACT-1:0] act_pulse;
  logic [15:0] act_arg;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int pulse2_cnt = 0;

  always #10 clk = ~clk;

  cmd_reg_bridge u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .status_in(status_in), .cfg_out(cfg_out),
    .act_pulse(act_pulse), .act_arg(act_arg)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int          m_nb, m_cnt, m_ptr;
  logic [31:0] m_word;
  bit          m_pend, m_ov;
  logic [15:0] m_od, m_arg;
  logic [15:0] m_cfg [NCFG];
  logic [NACT-1:0] m_act;
  logic [15:0] m_mem [DEPTH];

  always @(negedge clk) begin
    if (!rst_n) begin
      m_nb = 0; m_cnt = 0; m_ptr = 0; m_word = '0; m_pend = 0; m_ov = 0;
      m_od = '0; m_arg = '0; m_act = '0;
      for (int i = 0; i < NCFG; i++) m_cfg[i] = '0;
      for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
    end else begin
      bit fire, rd, old_pend;
      int a;
      logic [15:0] d, v;
      // compare current state
      chk(in_ready == !m_pend, "R1 model in_ready", 64'(in_ready), 64'(!m_pend));
      chk(out_valid == m_ov, "R9 model out_valid", 64'(out_valid), 64'(m_ov));
      if (m_ov) chk(out_data == m_od, "R9 model out_data", 64'(out_data), 64'(m_od));
      for (int i = 0; i < NCFG; i++)
        chk(cfg_out[i*16 +: 16] == m_cfg[i], "R3 model cfg_out", 64'(cfg_out[i*16 +: 16]), 64'(m_cfg[i]));
      chk(act_pulse == m_act, "R5 model act_pulse", 64'(act_pulse), 64'(m_act));
      if (m_act != 0) chk(act_arg == m_arg, "R5 model act_arg", 64'(act_arg), 64'(m_arg));
      // advance to the state after the coming edge
      old_pend = m_pend;
      rd = m_word[31];
      a  = int'(m_word[27:16]);
      d  = m_word[15:0];
      fire = m_pend && (!rd || !m_ov || out_ready);
      m_act = '0;
      v = '0;
      if (fire) begin
        m_pend = 0;
        if (rd) begin
          if (a >= 16 && a < 16 + NCFG) v = m_cfg[a-16];
          else if (a >= 32 && a < 32 + NSTAT) v = status_in[(a-32)*16 +: 16];
          else if (a == 64) v = 16'(m_cnt);
          else if (a == 65) v = 16'(m_ptr);
          else if (a == 66 && m_cnt != 0) begin
            v = m_mem[m_ptr]; m_ptr = (m_ptr + 1) % DEPTH; m_cnt--;
          end
        end else begin
          if (a >= 16 && a < 16 + NCFG) m_cfg[a-16] = d;
          else if (a >= 48 && a < 48 + NACT) begin m_act[a-48] = 1'b1; m_arg = d; end
          else if (a == 64) m_cnt = int'(d);
          else if (a == 65) m_ptr = int'(d) % DEPTH;
          else if (a == 66 && m_cnt != 0) begin
            m_mem[m_ptr] = d; m_ptr = (m_ptr + 1) % DEPTH; m_cnt--;
          end
        end
      end
      if (fire && rd) begin m_ov = 1; m_od = v; end
      else if (out_ready) m_ov = 0;
      if (in_valid && !old_pend) begin
        m_word = {m_word[23:0], in_data};
        m_nb++;
        if (m_nb == 4) begin m_nb = 0; m_pend = 1; end
      end
    end
  end

  always @(negedge clk) if (rst_n && act_pulse[2]) pulse2_cnt++;

  // ---------------- stimulus helpers ----------------
  task automatic send_byte(input logic [7:0] b);
    in_valid = 1'b1;
    in_data  = b;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic send_cmd(input logic [31:0] w);
    send_byte(w[31:24]);
    send_byte(w[23:16]);
    send_byte(w[15:8]);
    send_byte(w[7:0]);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pop_expect(input logic [15:0] exp, input string tag);
    @(negedge clk);
    while (!out_valid) @(negedge clk);
    chk(out_data == exp, tag, 64'(out_data), 64'(exp));
    @(posedge clk); #1 out_ready = 1'b1;
    @(posedge clk); #1 out_ready = 1'b0;
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 50000) begin
      errors++;
      $display("FAIL R9 watchdog expired actual=%0d expected<%0d cycles", cyc, 50000);
      finish_run();
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(in_ready == 1'b1, "R11 in_ready after reset", 64'(in_ready), 64'd1);
    chk(out_valid == 1'b0, "R11 out_valid after reset", 64'(out_valid), 64'd0);
    chk(cfg_out == '0, "R11 cfg_out after reset", 64'(cfg_out), 64'd0);
    chk(act_pulse == '0, "R11 act_pulse after reset", 64'(act_pulse), 64'd0);
    @(posedge clk); #1;
    send_cmd(32'h8040_0000);
    pop_expect(16'h0000, "R11 count after reset");

    // R2/R3: undefined bits set on a write, then read back
    send_cmd(32'h7010_BEEF);
    idle(2);
    chk(cfg_out[15:0] == 16'hBEEF, "R2 R3 cfg0 after write", 64'(cfg_out[15:0]), 64'hBEEF);
    send_cmd(32'h8010_0000);
    pop_expect(16'hBEEF, "R3 cfg0 readback");
    send_cmd(32'h0011_1234);
    send_cmd(32'hF011_0000);
    pop_expect(16'h1234, "R2 cfg1 read with undefined bits set");

    // R4 status
    send_cmd(32'h8021_0000);
    pop_expect(16'hA5A5, "R4 status1 read");
    send_cmd(32'h0021_FFFF);
    send_cmd(32'h8021_0000);
    pop_expect(16'hA5A5, "R4 status after write attempt");
    send_cmd(32'h8020_0000);
    pop_expect(16'h1357, "R4 status0 read");

    // R5 action
    send_cmd(32'h0032_00AB);
    idle(3);
    chk(pulse2_cnt == 1, "R5 one pulse on action 2", 64'(pulse2_cnt), 64'd1);
    chk(act_arg == 16'h00AB, "R5 action argument", 64'(act_arg), 64'h00AB);
    send_cmd(32'h8032_0000);
    pop_expect(16'h0000, "R5 action read returns zero");

    // R6/R7 indirect writes with wrap and count exhaustion
    send_cmd(32'h0040_0003);
    send_cmd(32'h0041_000E);
    send_cmd(32'h0042_1111);
    send_cmd(32'h0042_2222);
    send_cmd(32'h0042_3333);
    send_cmd(32'h0042_4444);
    send_cmd(32'h8040_0000);
    pop_expect(16'h0000, "R7 count after three stores");
    send_cmd(32'h8041_0000);
    pop_expect(16'h0001, "R6 R7 pointer wrapped");

    // R8 indirect reads
    send_cmd(32'h0041_000E);
    send_cmd(32'h0040_0002);
    send_cmd(32'h8042_0000);
    pop_expect(16'h1111, "R8 data read word 14");
    send_cmd(32'h8042_0000);
    pop_expect(16'h2222, "R8 data read word 15");
    send_cmd(32'h8042_0000);
    pop_expect(16'h0000, "R8 data read with count zero");
    send_cmd(32'h8041_0000);
    pop_expect(16'h0000, "R8 pointer after reads");
    send_cmd(32'h0040_0002);
    send_cmd(32'h8042_0000);
    pop_expect(16'h3333, "R6 wrapped store at word 0");
    send_cmd(32'h8042_0000);
    pop_expect(16'h0000, "R7 ignored store left word 1 empty");

    // R10 unmapped
    send_cmd(32'h0100_FFFF);
    send_cmd(32'h8100_0000);
    pop_expect(16'h0000, "R10 unmapped read");
    chk(cfg_out == {16'h0, 16'h0, 16'h1234, 16'hBEEF}, "R10 cfg untouched",
        64'(cfg_out), {16'h0, 16'h0, 16'h1234, 16'hBEEF});

    // R9 stall with full slot
    send_cmd(32'h8010_0000);
    send_cmd(32'h8011_0000);
    repeat (3) begin
      @(negedge clk);
      chk(in_ready == 1'b0, "R9 input closed while read waits", 64'(in_ready), 64'd0);
      chk(out_data == 16'hBEEF, "R9 first answer held", 64'(out_data), 64'hBEEF);
    end
    @(posedge clk); #1;
    pop_expect(16'hBEEF, "R9 first answer in order");
    pop_expect(16'h1234, "R9 second answer in order");
    // R1 byte order check through a full round trip
    send_cmd(32'h0013_A1B2);
    send_cmd(32'h8013_0000);
    pop_expect(16'hA1B2, "R1 byte order");

    idle(4);
    finish_run();
  end
endmodule